// File: doc/BRIEF.md
# FIFO-Gated SPI Master

This block is a serial peripheral interface master that moves a programmed number of frames between two 32-entry FIFOs and the serial lines. A frame is 8 or 16 bits and goes out most significant bit first. The clock idle level and the sampling edge are set per transfer, which gives all four SPI modes. The serial clock is the core clock divided by an even number. In transmit-and-receive mode each frame consumes one transmit entry. In receive-only mode the master clocks frames in with the data-out line held low and needs no transmit entries.

The configuration inputs (mode bits, divider, frame count) are held steady while the enable input is low. Lowering enable stops the engine, empties both FIFOs and reloads the frame counter. After enable goes high the core runs exactly count-plus-one frames. If a frame cannot start because the receive FIFO is full, or because transmit-and-receive mode has no transmit entry, the master does not overrun or send filler. It parks the serial clock at its idle level and starts the frame once the condition clears. The chip-select outputs follow a one-hot select input. They stay asserted between frames until the select input is cleared.

Top module: `spi_fifo_master`

## Requirements
- R1: Each half period of the serial clock within a frame lasts `clk_div_i/2` core clock cycles, for even divider values from 2 to 65534.
- R2: With `frame_cnt_i` = N, enabling the core moves exactly N+1 frames. Afterwards `busy_o` is low and no further clock edges occur.
- R3: `cpol_i` sets the idle level of `sclk_o`. With `cpha_i`=0 data is sampled on the first edge of each bit; with `cpha_i`=1 it is launched on the first edge and sampled on the second. Bits go out and come in most significant bit first.
- R4: With `frame16_i`=0 a frame is 8 bits. It sends bits [7:0] of the transmit entry and stores the received byte in bits [7:0] of the receive entry, with bits [15:8] zero. With `frame16_i`=1 the whole 16-bit entry is used.
- R5: Each FIFO holds 32 entries. `tx_full_o` is high when the transmit FIFO holds 32 entries. `rx_empty_o` is high when the receive FIFO is empty. `rx_level_o` reports 0 to 32.
- R6: In transmit-and-receive mode (`rx_only_i`=0) with the transmit FIFO empty, no frame starts: `sclk_o` stays at its idle level and `busy_o` stays high. Shifting resumes when data is pushed.
- R7: With the receive FIFO full, no frame starts and `sclk_o` stays idle. Popping an entry lets the next frame run, so no received data is lost.
- R8: In receive-only mode (`rx_only_i`=1) frames run without transmit entries and `mosi_o` stays low.
- R9: While `en_i` is low, both FIFOs are empty one cycle later, `busy_o` is low and `sclk_o` sits at its idle level.
- R10: `cs_o` follows `cs_sel_i` one cycle later and stays asserted across frame gaps and after the transfer until `cs_sel_i` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Core enable; low halts and flushes |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | 0: sample on first edge, 1: launch on first edge |
| frame16_i | input | 1 | 1: 16-bit frames, 0: 8-bit frames |
| rx_only_i | input | 1 | 1: receive-only mode |
| clk_div_i | input | 16 | Even clock divider, 2..65534 |
| frame_cnt_i | input | 16 | Number of frames minus one |
| cs_sel_i | input | 4 | One-hot chip-select request |
| tx_push_i | input | 1 | Write an entry to the transmit FIFO |
| tx_data_i | input | 16 | Transmit entry |
| rx_pop_i | input | 1 | Remove the head of the receive FIFO |
| rx_data_o | output | 16 | Head of the receive FIFO |
| busy_o | output | 1 | Frames remain in the current transfer |
| tx_full_o | output | 1 | Transmit FIFO full |
| rx_empty_o | output | 1 | Receive FIFO empty |
| rx_level_o | output | 6 | Receive FIFO occupancy |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines, active high |

## Verification
The hardest states to reach from the ports are the two stall conditions, because a normal transfer keeps both FIFOs moving. The bench reaches transmit starvation by pushing one entry of a three-frame transfer and then waiting. It fills the receive FIFO with a 40-frame receive-only transfer and no pops, then checks that the clock is parked, exactly 32 frames have appeared on the wire and the remaining 8 arrive in order once the FIFO is drained. A slave model in the bench follows the selected mode, drives its own data pattern and records what it receives, so the sampling and launch edges are checked in both directions.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic frame16;
    logic rx_only;
  } spi_cfg_t;
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [LW-1:0] level_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign level_o = cnt_q;
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + LW'(do_push) - LW'(do_pop);
    end
  end

  a_r5_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH));
  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_fifo_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int EW = $clog2(2 * DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  spi_cfg_t      cfg_i,
  input  logic [CW-1:0] clk_div_i,
  input  logic [CW-1:0] frame_cnt_i,
  input  logic          tx_empty_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_pop_o,
  input  logic          rx_full_i,
  output logic          rx_push_o,
  output logic [DW-1:0] rx_data_o,
  output logic          busy_o,
  output logic          sclk_o,
  output logic          mosi_o,
  input  logic          miso_i
);
  logic          active_q, sclk_q, mosi_q;
  logic [CW-1:0] hcnt_q;
  logic [EW-1:0] eidx_q;
  logic [DW-1:0] tx_sh_q, rx_sh_q;
  logic [CW:0]   rem_q;
  logic [CW-1:0] half_m1;
  logic [EW-1:0] last_e;
  logic can_start, edge_now, samp_e, launch_e, frame_end;
  logic [DW-1:0] load_val, rx_final;

  assign half_m1   = (clk_div_i[CW-1:1] == '0) ? '0 : CW'(clk_div_i[CW-1:1]) - 1'b1;
  assign last_e    = cfg_i.frame16 ? EW'(2 * DW - 1) : EW'(DW - 1);
  assign can_start = en_i && !active_q && (rem_q != '0) && !rx_full_i &&
                     (cfg_i.rx_only || !tx_empty_i);
  assign edge_now  = active_q && (hcnt_q == half_m1);
  assign samp_e    = (eidx_q[0] == cfg_i.cpha);
  // with cpha set the first edge launches the bit already on the line
  assign launch_e  = !samp_e && !(cfg_i.cpha && eidx_q == '0);
  assign frame_end = edge_now && (eidx_q == last_e);
  assign load_val  = cfg_i.rx_only ? '0 :
                     (cfg_i.frame16 ? tx_data_i : {tx_data_i[7:0], {(DW-8){1'b0}}});
  assign rx_final  = cfg_i.cpha ? {rx_sh_q[DW-2:0], miso_i} : rx_sh_q;

  assign tx_pop_o  = can_start && !cfg_i.rx_only;
  assign rx_push_o = frame_end;
  assign rx_data_o = cfg_i.frame16 ? rx_final : {{(DW-8){1'b0}}, rx_final[7:0]};
  assign busy_o    = en_i && (rem_q != '0);
  assign sclk_o    = sclk_q;
  assign mosi_o    = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0;
      hcnt_q <= '0; eidx_q <= '0; tx_sh_q <= '0; rx_sh_q <= '0; rem_q <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      sclk_q   <= cfg_i.cpol;
      mosi_q   <= 1'b0;
      hcnt_q   <= '0;
      eidx_q   <= '0;
      rem_q    <= {1'b0, frame_cnt_i} + 1'b1;
    end else if (can_start) begin
      active_q <= 1'b1;
      hcnt_q   <= '0;
      eidx_q   <= '0;
      tx_sh_q  <= load_val;
      mosi_q   <= load_val[DW-1];
      rx_sh_q  <= '0;
    end else if (active_q) begin
      if (edge_now) begin
        hcnt_q <= '0;
        sclk_q <= ~sclk_q;
        eidx_q <= eidx_q + 1'b1;
        if (samp_e) rx_sh_q <= {rx_sh_q[DW-2:0], miso_i};
        if (launch_e) begin
          tx_sh_q <= {tx_sh_q[DW-2:0], 1'b0};
          mosi_q  <= tx_sh_q[DW-2];
        end
        if (frame_end) begin
          active_q <= 1'b0;
          rem_q    <= rem_q - 1'b1;
        end
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  a_r6_pop_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i);
  a_r7_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> !rx_full_i);
  a_r2_no_extra_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> busy_o);
  a_r9_disable_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!active_q && sclk_q == $past(cfg_i.cpol)));
  a_r3_idle_clock_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !active_q && !$past(active_q)) |-> $stable(sclk_q));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int DEPTH = 32,
  parameter int NCS = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          frame16_i,
  input  logic          rx_only_i,
  input  logic [CW-1:0] clk_div_i,
  input  logic [CW-1:0] frame_cnt_i,
  input  logic [NCS-1:0] cs_sel_i,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  output logic          busy_o,
  output logic          tx_full_o,
  output logic          rx_empty_o,
  output logic [LW-1:0] rx_level_o,
  output logic          sclk_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic [NCS-1:0] cs_o
);
  spi_cfg_t      cfg;
  logic          tx_empty, tx_pop, rx_full, rx_push;
  logic [DW-1:0] tx_head, rx_word;
  logic [LW-1:0] tx_level;
  logic [NCS-1:0] cs_q;

  assign cfg = '{cpol: cpol_i, cpha: cpha_i, frame16: frame16_i, rx_only: rx_only_i};

  spi_sync_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(!en_i),
    .push_i(tx_push_i), .wdata_i(tx_data_i),
    .pop_i(tx_pop), .rdata_o(tx_head),
    .full_o(tx_full_o), .empty_o(tx_empty), .level_o(tx_level)
  );

  spi_sync_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(!en_i),
    .push_i(rx_push), .wdata_i(rx_word),
    .pop_i(rx_pop_i), .rdata_o(rx_data_o),
    .full_o(rx_full), .empty_o(rx_empty_o), .level_o(rx_level_o)
  );

  spi_shift_engine #(.DW(DW), .CW(CW)) u_engine (
    .clk_i, .rst_ni, .en_i, .cfg_i(cfg),
    .clk_div_i, .frame_cnt_i,
    .tx_empty_i(tx_empty), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
    .rx_full_i(rx_full), .rx_push_o(rx_push), .rx_data_o(rx_word),
    .busy_o, .sclk_o, .mosi_o, .miso_i
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= '0;
    else         cs_q <= cs_sel_i;
  end
  assign cs_o = cs_q;

  a_r10_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_q));
  a_r5_tx_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_o |-> (tx_level == LW'(DEPTH)));
endmodule

// File: tb/spi_fifo_master_tb_top.sv
module spi_fifo_master_tb_top;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic en = 0, cpol = 0, cpha = 0, f16 = 1, rxo = 0;
  logic [15:0] div = 16'd2, fcnt = 16'd0;
  logic [3:0] cs_sel = 4'b0;
  logic tx_push = 0, rx_pop = 0;
  logic [15:0] tx_data = 0;
  logic [15:0] rx_data;
  logic busy, tx_full, rx_empty, sclk, mosi, miso;
  logic [5:0] rx_level;
  logic [3:0] cs;

  spi_fifo_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol), .cpha_i(cpha),
    .frame16_i(f16), .rx_only_i(rxo), .clk_div_i(div), .frame_cnt_i(fcnt),
    .cs_sel_i(cs_sel), .tx_push_i(tx_push), .tx_data_i(tx_data), .rx_pop_i(rx_pop),
    .rx_data_o(rx_data), .busy_o(busy), .tx_full_o(tx_full), .rx_empty_o(rx_empty),
    .rx_level_o(rx_level), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_o(cs)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] salt = 16'h5a3c;
  logic [15:0] txw [64];

  function automatic logic [15:0] sw(input int k);
    return 16'hc3a5 ^ (16'(k) * 16'h1357) ^ salt;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model: updates on the negedge after each sclk edge
  int se = 0, scnt = 0, gap = 0, bad_half = 0;
  logic [15:0] ssh = 0, scap_sh = 0;
  logic [15:0] scap [64];
  logic sprev = 0;
  assign miso = ssh[15];

  always @(negedge clk) begin
    bit samp, launch;
    gap++;
    if (!en) begin
      se = 0; scnt = 0; ssh = sw(0); sprev = sclk; gap = 0; scap_sh = 0;
    end else if (sclk != sprev) begin
      sprev = sclk;
      if (se != 0 && gap != int'(div / 2)) bad_half++;
      gap = 0;
      samp = (se[0] == cpha);
      launch = !samp && !(cpha && se == 0);
      if (samp) scap_sh = {scap_sh[14:0], mosi};
      if (launch) ssh = {ssh[14:0], 1'b0};
      se++;
      if (se == (f16 ? 32 : 16)) begin
        se = 0;
        if (scnt < 64) scap[scnt] = scap_sh;
        scnt++;
        ssh = sw(scnt);
        scap_sh = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic setup(input bit p, input bit h, input bit s16, input bit ro,
                       input logic [15:0] d, input logic [15:0] n);
    @(negedge clk);
    en = 0; tx_push = 0; rx_pop = 0;
    cpol = p; cpha = h; f16 = s16; rxo = ro; div = d; fcnt = n;
    salt = 16'($urandom);
    repeat (3) @(negedge clk);
    bad_half = 0;
  endtask

  function automatic logic [15:0] exp_rx(input int k);
    logic [15:0] w = sw(k);
    return f16 ? w : {8'h00, w[15:8]};
  endfunction

  task automatic run_xfer();
    int n = int'(fcnt) + 1;
    int pushed = 0, popped = 0, guard = 0, bad_rx = 0, bad_cap = 0, mhi = 0;
    for (int i = 0; i < n && i < 64; i++) txw[i] = 16'($urandom);
    en = 1;
    while (popped < n && guard < 20000) begin
      @(negedge clk);
      tx_push = 0; rx_pop = 0;
      if (mosi) mhi++;
      if (!rxo && pushed < n && !tx_full) begin
        tx_push = 1; tx_data = txw[pushed]; pushed++;
      end
      if (!rx_empty) begin
        if (rx_data != exp_rx(popped)) bad_rx++;
        rx_pop = 1; popped++;
      end
      guard++;
    end
    @(negedge clk); tx_push = 0; rx_pop = 0;
    repeat (4) @(negedge clk);
    check(!busy, "R2 busy after last frame", busy, 0);
    check(scnt == n, "R2 frames on wire", scnt, n);
    check(sclk == cpol, "R3 idle level", sclk, cpol);
    check(bad_rx == 0, "R3/R4 receive data", bad_rx, 0);
    check(bad_half == 0, "R1 half period", bad_half, 0);
    if (rxo) check(mhi == 0, "R8 mosi low", mhi, 0);
    else begin
      for (int i = 0; i < n; i++)
        if ((f16 ? scap[i] : {8'h0, scap[i][7:0]}) !=
            (f16 ? txw[i] : {8'h0, txw[i][7:0]})) bad_cap++;
      check(bad_cap == 0, "R3/R4 transmit data", bad_cap, 0);
    end
  endtask

  initial begin
    int popped;
    logic [15:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && rx_empty && !tx_full && rx_level == 0 && cs == 0,
          "R9 reset state", {busy, rx_empty, tx_full, rx_level}, 6'b0);
    rst_n = 1;
    cs_sel = 4'b0100;

    // directed: four modes, 16-bit, minimum divider
    for (int m = 0; m < 4; m++) begin
      setup(m[1], m[0], 1, 0, 16'd2, 16'd4);
      run_xfer();
    end
    // directed: 8-bit receive-only and a wide divider
    setup(1, 1, 0, 1, 16'd40, 16'd2); run_xfer();
    setup(0, 1, 0, 0, 16'd6, 16'd5); run_xfer();
    // random configurations
    for (int r = 0; r < 8; r++) begin
      setup($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
            16'(2 * (1 + $urandom % 4)), 16'($urandom % 12));
      run_xfer();
    end

    // R6: transmit starvation
    setup(1, 0, 1, 0, 16'd4, 16'd2);
    en = 1; txw[0] = 16'h9ab1; txw[1] = 16'h0f0f; txw[2] = 16'h7e81;
    tx_push = 1; tx_data = txw[0];
    @(negedge clk); tx_push = 0;
    repeat (200) @(negedge clk);
    check(busy && sclk == 1, "R6 parked while starved", {busy, sclk}, 2'b11);
    check(scnt == 1, "R6 one frame only", scnt, 1);
    check(cs == 4'b0100, "R10 select held between frames", cs, 4'b0100);
    for (int i = 1; i < 3; i++) begin
      tx_push = 1; tx_data = txw[i]; @(negedge clk);
    end
    tx_push = 0;
    repeat (200) @(negedge clk);
    check(!busy && scnt == 3, "R6 resumed", scnt, 3);
    check(scap[1] == txw[1] && scap[2] == txw[2], "R6 data after resume", scap[2], txw[2]);
    popped = 0;
    while (!rx_empty) begin
      if (rx_data != sw(popped)) check(0, "R6 receive order", rx_data, sw(popped));
      rx_pop = 1; popped++; @(negedge clk); rx_pop = 0;
    end
    check(popped == 3, "R6 receive count", popped, 3);
    check(cs == 4'b0100, "R10 select held after transfer", cs, 4'b0100);
    cs_sel = 4'b0000; @(negedge clk);
    check(cs == 0, "R10 select released", cs, 0);
    cs_sel = 4'b0001; @(negedge clk);
    check(cs == 4'b0001, "R10 select follows input", cs, 4'b0001);

    // R7: receive FIFO full stall
    setup(0, 0, 0, 1, 16'd2, 16'd39);
    en = 1;
    repeat (2000) @(negedge clk);
    check(rx_level == 32 && !rx_empty, "R5 level at full", rx_level, 32);
    check(busy && sclk == 0, "R7 parked while full", {busy, sclk}, 2'b10);
    check(scnt == 32, "R7 frames before stall", scnt, 32);
    popped = 0;
    repeat (300) begin
      if (!rx_empty) begin
        w = {8'h0, sw(popped)[15:8]};
        if (rx_data != w) check(0, "R7 receive order", rx_data, w);
        rx_pop = 1; popped++;
      end else rx_pop = 0;
      @(negedge clk);
    end
    rx_pop = 0;
    check(popped == 40 && !busy, "R7 all frames kept", popped, 40);

    // R9: flush of held receive data
    setup(0, 1, 1, 1, 16'd2, 16'd5);
    en = 1;
    repeat (300) @(negedge clk);
    check(rx_level == 6, "R5 level count", rx_level, 6);
    en = 0; @(negedge clk);
    check(rx_level == 0 && rx_empty, "R9 receive flush", rx_level, 0);

    // R5 transmit full, then R9 disable mid-transfer
    setup(1, 0, 1, 0, 16'd1000, 16'd100);
    en = 1;
    for (int i = 0; i < 33; i++) begin
      tx_push = 1; tx_data = 16'(i); @(negedge clk);
    end
    tx_push = 0;
    check(tx_full, "R5 transmit full flag", tx_full, 1);
    check(busy && rx_empty, "R5 busy while shifting", {busy, rx_empty}, 2'b11);
    en = 0; @(negedge clk);
    check(!tx_full && !busy && rx_empty, "R9 halt and flush",
          {tx_full, busy, rx_empty}, 3'b001);
    check(sclk == 1, "R9 idle clock after halt", sclk, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule